// File: doc/BRIEF.md
# Legacy compatibility address router

This block sits on the host request path and decides where a request aimed at a legacy compatibility region goes. There are two destinations. The PCI bus claims such a request by subtractive decode. The fabric port routes it, either as a compatibility-flagged request or by address. Two controls pick the destination. A routing strap is captured during reset and covers the low I/O window (below 32 KB) and the low memory window (below 16 MB). A software-written VGA enable covers the VGA windows. Those windows are memory 0x0A0000 to 0x0BFFFF, and I/O 0x3B0 to 0x3BB and 0x3C0 to 0x3DF with address bits 15:10 ignored.

A VGA match always takes priority over the strap rule. Requests that leave for a compatibility region carry an address cut to 24 bits. Any other request goes through unchanged, with a flag that leaves it for a later decoder. The result is held in one registered stage with a valid/ready handshake. A parameter builds a single-port variant, in which every compatibility I/O access goes to PCI.

Top module: `compat_router`

## Requirements
- R1: An I/O request below 32 KB that does not match a VGA window goes to the fabric (out_to_fabric=1, 1 = fabric, 0 = PCI) with out_compat=1 when the captured strap is 1. It goes to PCI with out_compat=0 when the strap is 0. out_not_compat=0 in both cases.
- R2: A memory request below 16 MB that does not match a VGA window follows the same strap rule as R1.
- R3: A request in a VGA window ignores the strap. The memory window is 0x0A0000 to 0x0BFFFF. The I/O windows are 0x3B0 to 0x3BB and 0x3C0 to 0x3DF, compared on bits 9:0, with bits 15:10 ignored and bits above 15 required to be zero. When the VGA enable is 1 the request goes to the fabric with out_compat=0. When the enable is 0 it goes to PCI. out_not_compat=0 in both cases.
- R4: Any compatibility-region request leaves with address bits above 23 equal to zero and bits 23:0 unchanged.
- R5: Any other request leaves with out_not_compat=1, out_to_fabric=0, out_compat=0 and its address unmodified.
- R6: The strap is taken from strap_in on every clock while rst_n is low. After reset ends, later changes of strap_in have no effect.
- R7: The VGA enable resets to 0. It takes vga_wr_data on a clock where vga_wr_en is 1. A request accepted on that same clock still uses the old value.
- R8: The output stage resets empty (out_valid=0, in_ready=1). While out_valid=1 and out_ready=0 it holds its contents and in_ready=0. A new request is accepted in the same cycle the held one drains.
- R9: When SINGLE_PORT=1, every I/O request covered by R1 goes to PCI with out_compat=0, whatever the strap. VGA and memory routing do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_in | input | 1 | Routing strap, captured during reset |
| vga_wr_en | input | 1 | Write strobe for the VGA enable bit |
| vga_wr_data | input | 1 | Value written to the VGA enable bit |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_is_io | input | 1 | 1 = I/O request, 0 = memory request |
| in_addr | input | ADDR_W | Request address |
| out_valid | output | 1 | Routed request valid |
| out_ready | input | 1 | Downstream accepts the routed request |
| out_to_fabric | output | 1 | 1 = fabric port, 0 = PCI |
| out_compat | output | 1 | Compatibility flag on the fabric request |
| out_addr | output | ADDR_W | Routed address, masked for compatibility regions |
| out_not_compat | output | 1 | Request is outside all compatibility regions |

## Verification
Requests are sent at both edges of every window: just inside and just outside the 32 KB I/O limit, the 16 MB memory limit and each VGA range. This separates the strap rule, the VGA rule and pass-through. I/O addresses with bits 15:10 set, and with bits above 15 set, separate the aliased VGA match from a real miss. A VGA address inside the low windows shows which rule has priority. The strap is captured at 1 and then at 0, with strap_in changed after reset, to show the strap is held. A second single-port instance is compared under the same stimulus. Backpressure shows hold and same-cycle refill.

// File: rtl/compat_router.sv
module compat_router #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned IO_LIMIT  = 32'h0000_8000,
  parameter int unsigned MEM_LIMIT = 32'h0100_0000,
  parameter bit          SINGLE_PORT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_in,
  input  logic              vga_wr_en,
  input  logic              vga_wr_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_is_io,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_to_fabric,
  output logic              out_compat,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_not_compat
);

  localparam logic [ADDR_W-1:0] IO_TOP   = ADDR_W'(IO_LIMIT);
  localparam logic [ADDR_W-1:0] MEM_TOP  = ADDR_W'(MEM_LIMIT);
  localparam logic [ADDR_W-1:0] VMEM_LO  = ADDR_W'(32'h000A_0000);
  localparam logic [ADDR_W-1:0] VMEM_HI  = ADDR_W'(32'h000B_FFFF);

  logic strap_q, vga_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strap_q  <= strap_in;
      vga_en_q <= 1'b0;
    end else if (vga_wr_en) begin
      vga_en_q <= vga_wr_data;
    end
  end

  logic [9:0] lo10;
  logic io_vga, mem_vga, vga_hit, low_hit, fabric_d, compat_d;
  logic [ADDR_W-1:0] addr_d;

  assign lo10    = in_addr[9:0];
  assign io_vga  = in_is_io && (in_addr[ADDR_W-1:16] == '0) &&
                   ((lo10 >= 10'h3B0 && lo10 <= 10'h3BB) ||
                    (lo10 >= 10'h3C0 && lo10 <= 10'h3DF));
  assign mem_vga = !in_is_io && in_addr >= VMEM_LO && in_addr <= VMEM_HI;
  assign vga_hit = io_vga || mem_vga;
  assign low_hit = in_is_io ? (in_addr < IO_TOP) : (in_addr < MEM_TOP);

  assign fabric_d = vga_hit ? vga_en_q :
                    low_hit ? (strap_q && !(SINGLE_PORT && in_is_io)) : 1'b0;
  assign compat_d = !vga_hit && low_hit && fabric_d;
  assign addr_d   = (vga_hit || low_hit) ? {{(ADDR_W-24){1'b0}}, in_addr[23:0]} : in_addr;

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_to_fabric  <= 1'b0;
      out_compat     <= 1'b0;
      out_addr       <= '0;
      out_not_compat <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_valid      <= 1'b1;
      out_to_fabric  <= fabric_d;
      out_compat     <= compat_d;
      out_addr       <= addr_d;
      out_not_compat <= !(vga_hit || low_hit);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r1_compat_on_fabric: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_compat) |-> (out_to_fabric && !out_not_compat));

  a_r4_addr_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_not_compat) |-> (out_addr[ADDR_W-1:24] == '0));

  a_r5_passthrough_pci: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_not_compat) |-> (!out_to_fabric && !out_compat));

  a_r6_strap_held: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(strap_q));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) &&
      $stable(out_to_fabric) && $stable(out_compat) && $stable(out_not_compat)));

endmodule

// File: tb/test_compat_router.sv
module test_compat_router;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, strap_in, vga_wr_en, vga_wr_data, in_valid, in_is_io, out_ready;
  logic [31:0] in_addr;
  logic in_ready, out_valid, out_to_fabric, out_compat, out_not_compat;
  logic [31:0] out_addr;
  logic sp_in_ready, sp_valid, sp_fab, sp_cmp, sp_nc;
  logic [31:0] sp_addr;

  int checks = 0, failures = 0;

  compat_router i_compat_router (
    .clk, .rst_n, .strap_in, .vga_wr_en, .vga_wr_data, .in_valid, .in_ready,
    .in_is_io, .in_addr, .out_valid, .out_ready, .out_to_fabric, .out_compat,
    .out_addr, .out_not_compat);

  compat_router #(.SINGLE_PORT(1'b1)) i_compat_router_sp (
    .clk, .rst_n, .strap_in, .vga_wr_en, .vga_wr_data, .in_valid,
    .in_ready(sp_in_ready), .in_is_io, .in_addr, .out_valid(sp_valid), .out_ready,
    .out_to_fabric(sp_fab), .out_compat(sp_cmp), .out_addr(sp_addr),
    .out_not_compat(sp_nc));

  // {is_io, vga_en, addr, exp_fabric, exp_compat, exp_not_compat, exp_addr}, strap = 1
  localparam int NV = 18;
  localparam logic [68:0] VEC [0:NV-1] = '{
    {1'b1,1'b0,32'h0000_0060,1'b1,1'b1,1'b0,32'h0000_0060},
    {1'b1,1'b0,32'h0000_7FFF,1'b1,1'b1,1'b0,32'h0000_7FFF},
    {1'b1,1'b0,32'h0000_8000,1'b0,1'b0,1'b1,32'h0000_8000},
    {1'b0,1'b0,32'h00FF_FFFF,1'b1,1'b1,1'b0,32'h00FF_FFFF},
    {1'b0,1'b0,32'h0100_0000,1'b0,1'b0,1'b1,32'h0100_0000},
    {1'b0,1'b0,32'h000A_0000,1'b0,1'b0,1'b0,32'h000A_0000},
    {1'b0,1'b1,32'h000B_FFFF,1'b1,1'b0,1'b0,32'h000B_FFFF},
    {1'b0,1'b1,32'h0009_FFFF,1'b1,1'b1,1'b0,32'h0009_FFFF},
    {1'b0,1'b1,32'h000C_0000,1'b1,1'b1,1'b0,32'h000C_0000},
    {1'b1,1'b1,32'h0000_03BB,1'b1,1'b0,1'b0,32'h0000_03BB},
    {1'b1,1'b0,32'h0000_03BC,1'b1,1'b1,1'b0,32'h0000_03BC},
    {1'b1,1'b0,32'h0000_83B0,1'b0,1'b0,1'b0,32'h0000_83B0},
    {1'b1,1'b1,32'h0000_FFDF,1'b1,1'b0,1'b0,32'h0000_FFDF},
    {1'b1,1'b0,32'h0000_03DF,1'b0,1'b0,1'b0,32'h0000_03DF},
    {1'b1,1'b1,32'h0000_03E0,1'b1,1'b1,1'b0,32'h0000_03E0},
    {1'b1,1'b1,32'h0001_03C0,1'b0,1'b0,1'b1,32'h0001_03C0},
    {1'b0,1'b1,32'hF00A_0000,1'b0,1'b0,1'b1,32'hF00A_0000},
    {1'b0,1'b0,32'h0000_0000,1'b1,1'b1,1'b0,32'h0000_0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_vga(input logic v);
    @(negedge clk); vga_wr_en = 1'b1; vga_wr_data = v;
    @(negedge clk); vga_wr_en = 1'b0;
  endtask

  task automatic send(input logic io, input logic [31:0] a);
    @(negedge clk); in_valid = 1'b1; in_is_io = io; in_addr = a;
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk); rst_n = 1'b0; strap_in = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic chk_out(input string req, input logic f, input logic c, input logic n, input logic [31:0] a);
    chk(req, {out_valid, out_to_fabric, out_compat, out_not_compat, out_addr},
             {1'b1, f, c, n, a});
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; strap_in = 1'b1; vga_wr_en = 1'b0; vga_wr_data = 1'b0;
    in_valid = 1'b0; in_is_io = 1'b0; in_addr = '0; out_ready = 1'b1;
    do_reset(1'b1);
    @(negedge clk);
    chk("R8 reset empty", {out_valid, in_ready}, {1'b0, 1'b1});

    // Table: R1 R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      set_vga(VEC[i][67]);
      send(VEC[i][68], VEC[i][66:35]);
      chk_out($sformatf("R1/R2/R3/R4/R5 vec %0d", i),
              VEC[i][34], VEC[i][33], VEC[i][32], VEC[i][31:0]);
    end

    // R7: the write and the request on the same clock use the old enable
    set_vga(1'b0);
    @(negedge clk); vga_wr_en = 1'b1; vga_wr_data = 1'b1;
    in_valid = 1'b1; in_is_io = 1'b0; in_addr = 32'h000A_0000;
    @(negedge clk); vga_wr_en = 1'b0; in_valid = 1'b0;
    chk_out("R7 same-cycle write uses old enable", 1'b0, 1'b0, 1'b0, 32'h000A_0000);
    send(1'b0, 32'h000A_0000);
    chk_out("R7 enable written", 1'b1, 1'b0, 1'b0, 32'h000A_0000);

    // R9: single-port instance, strap = 1
    send(1'b1, 32'h0000_0060);
    chk("R9 single-port io to PCI", {sp_valid, sp_fab, sp_cmp, sp_nc}, {1'b1, 1'b0, 1'b0, 1'b0});
    send(1'b0, 32'h0000_0100);
    chk("R9 single-port mem still strap", {sp_valid, sp_fab, sp_cmp, sp_nc}, {1'b1, 1'b1, 1'b1, 1'b0});
    send(1'b1, 32'h0000_03C0);
    chk("R9 single-port vga still enable", {sp_valid, sp_fab, sp_cmp}, {1'b1, 1'b1, 1'b0});

    // R6: strap change after reset ignored
    @(negedge clk); strap_in = 1'b0;
    send(1'b1, 32'h0000_0060);
    chk_out("R6 strap held after reset", 1'b1, 1'b1, 1'b0, 32'h0000_0060);

    // R7: reset clears enable; R6 capture of 0
    do_reset(1'b0);
    strap_in = 1'b1;
    send(1'b0, 32'h000A_0000);
    chk_out("R7 enable cleared by reset", 1'b0, 1'b0, 1'b0, 32'h000A_0000);
    send(1'b1, 32'h0000_0060);
    chk_out("R1 strap 0 io to PCI", 1'b0, 1'b0, 1'b0, 32'h0000_0060);
    send(1'b0, 32'h0000_0100);
    chk_out("R2 strap 0 mem to PCI", 1'b0, 1'b0, 1'b0, 32'h0000_0100);
    set_vga(1'b1);
    send(1'b1, 32'h0000_07B4);
    chk_out("R3 vga ignores strap 0", 1'b1, 1'b0, 1'b0, 32'h0000_07B4);

    // R8: backpressure and same-cycle refill
    @(negedge clk); out_ready = 1'b0;
    in_valid = 1'b1; in_is_io = 1'b0; in_addr = 32'h0200_0000;
    @(negedge clk); in_addr = 32'h0300_0000;
    chk("R8 in_ready low when full", in_ready, 1'b0);
    @(negedge clk);
    chk_out("R8 holds first", 1'b0, 1'b0, 1'b1, 32'h0200_0000);
    out_ready = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    chk_out("R8 refill on drain", 1'b0, 1'b0, 1'b1, 32'h0300_0000);
    @(negedge clk);
    chk("R8 drains empty", out_valid, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule